// File: doc/BRIEF.md
# Illegal Condition Reset Detector

This block sits beside a processor core and watches three streams of activity: instruction words as they are fetched, working-register writes and uses of a register as an address pointer, and every reload of the program counter. It raises a device reset request when it sees any of three faults. The first is an opcode whose top byte carries the reserved illegal value. The second is an address-pointer use of a working register that has not been written since the last reset. The third is a jump, call, return or interrupt/trap vector that lands inside one of the protected code segments at an address other than an allowed entry point.

The reasons are reported as a 3-bit cause vector with one bit per fault class. When several faults arrive in the same cycle, all of their bits are reported together with a single request. The request and the cause stay latched until the device reset, `rst_n`, arrives. That reset also returns every working register except the top one (the stack pointer) to the uninitialised state.

Control is a two-state machine. In `ST_WATCH` the outputs are idle and the three detectors are sampled each cycle. The `fire` transition moves to `ST_ASSERT` when any detector hits, and it captures the hit vector at that moment. The `hold` transition keeps `ST_ASSERT` in place on every later cycle. The only exit is the `reset exit` transition back to `ST_WATCH`, which happens when `rst_n` is low.

Top module: `icr_reset_ctrl`

## Requirements
- R1: While and after `rst_n` is low, `rst_req` is 0 and `cause` is 3'b000 until a fault is seen.
- R2: When `fetch_vld` is 1 and `fetch_word[23:16]` equals 8'h3F, `rst_req` is 1 and `cause[0]` is 1 after the next rising clock edge. Any other top byte raises nothing.
- R3: Each reset marks registers 0 to 14 as uninitialised. A pointer use (`ptr_vld`) of such a register raises `rst_req` with `cause[1]` after the next edge.
- R4: A pointer use of register 15 (`ptr_idx` = 4'hF) never raises a request.
- R5: A register counts as initialised from the cycle it is first written. This includes a write to the same index in the same cycle as the pointer use. A write to a different index does not initialise the register being used.
- R6: When `pc_load` is 1 and `pc_target` lies within `seg_lo[s]`..`seg_hi[s]` inclusive for either segment s, and differs from both of that segment's `seg_entry[s]` addresses, `rst_req` is raised with `cause[2]`.
- R7: A PC reload that lands on an allowed entry point, lands outside every segment, or lands in a segment whose `seg_lo` is greater than its `seg_hi` raises nothing.
- R8: Faults of different classes in the same cycle raise one request whose `cause` holds every active bit.
- R9: Once raised, `rst_req` stays 1 and `cause` stays unchanged until `rst_n` goes low, whatever faults follow.
- R10: The word, index and target inputs have no effect while their strobe (`fetch_vld`, `ptr_vld`, `pc_load`) is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low device reset |
| fetch_vld | input | 1 | Instruction word fetched this cycle |
| fetch_word | input | 24 | Fetched instruction word |
| wr_vld | input | 1 | Working register written this cycle |
| wr_idx | input | 4 | Index of the written register |
| ptr_vld | input | 1 | Working register used as address pointer |
| ptr_idx | input | 4 | Index of the pointer register |
| pc_load | input | 1 | Program counter reloaded (branch, return or vector) |
| pc_target | input | 24 | New program counter value |
| seg_lo | input | 2x24 | Lowest address of each protected segment |
| seg_hi | input | 2x24 | Highest address of each protected segment |
| seg_entry | input | 2x2x24 | Allowed entry addresses of each segment |
| rst_req | output | 1 | Device reset request, latched |
| cause | output | 3 | Bit 0 illegal opcode, bit 1 uninitialised pointer, bit 2 protected-segment entry |

## Verification
The assertions assume the segment bounds and entry lists are held steady while `rst_n` is high. They also assume that register 15 is the only exempt index and that strobes are sampled only at rising edges. The bench changes segment configuration only between tests, and it changes it only while the design is held in reset or before the next PC reload. It drives every strobe and payload on the falling edge, so each fault is presented for exactly one clean sampling edge. Each vector starts from a fresh reset, so the latched request of one case never hides the next one.

// File: rtl/icr_pkg.sv
package icr_pkg;
    localparam int CAUSE_W      = 3;
    localparam int CAUSE_OPCODE = 0;
    localparam int CAUSE_WREG   = 1;
    localparam int CAUSE_FLOW   = 2;

    typedef enum logic {
        ST_WATCH  = 1'b0,
        ST_ASSERT = 1'b1
    } icr_state_e;
endpackage

// File: rtl/icr_opcode_chk.sv
module icr_opcode_chk #(
    parameter int              WORD_W     = 24,
    parameter int              OP_W       = 8,
    parameter logic [OP_W-1:0] ILLEGAL_OP = 8'h3F
) (
    input  logic              fetch_vld,
    input  logic [WORD_W-1:0] fetch_word,
    output logic              hit
);
    localparam int OP_LSB = WORD_W - OP_W;

    logic unused_low_bits;
    assign unused_low_bits = ^fetch_word[OP_LSB-1:0];

    always_comb begin
        hit = fetch_vld && (fetch_word[WORD_W-1:OP_LSB] == ILLEGAL_OP);
    end
endmodule

// File: rtl/icr_wreg_track.sv
module icr_wreg_track #(
    parameter int NUM_REG    = 16,
    parameter bit EXEMPT_TOP = 1'b1,
    localparam int IDX_W     = $clog2(NUM_REG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_vld,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             ptr_vld,
    input  logic [IDX_W-1:0] ptr_idx,
    output logic             hit
);
    logic [NUM_REG-1:0] init_flag;

    for (genvar g = 0; g < NUM_REG; g++) begin : g_reg
        if (EXEMPT_TOP && (g == NUM_REG - 1)) begin : g_exempt
            assign init_flag[g] = 1'b1;
        end else begin : g_tracked
            logic written_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    written_q <= 1'b0;
                end else if (wr_vld && (wr_idx == IDX_W'(g))) begin
                    written_q <= 1'b1;
                end
            end
            assign init_flag[g] = written_q;
        end
    end

    logic same_cycle_write;

    always_comb begin
        same_cycle_write = wr_vld && (wr_idx == ptr_idx);
        hit = ptr_vld && !init_flag[ptr_idx] && !same_cycle_write;
    end
endmodule

// File: rtl/icr_flow_guard.sv
module icr_flow_guard #(
    parameter int ADDR_W    = 24,
    parameter int NUM_SEG   = 2,
    parameter int NUM_ENTRY = 2
) (
    input  logic                                         pc_load,
    input  logic [ADDR_W-1:0]                            pc_target,
    input  logic [NUM_SEG-1:0][ADDR_W-1:0]               seg_lo,
    input  logic [NUM_SEG-1:0][ADDR_W-1:0]               seg_hi,
    input  logic [NUM_SEG-1:0][NUM_ENTRY-1:0][ADDR_W-1:0] seg_entry,
    output logic                                         hit
);
    logic [NUM_SEG-1:0] restricted;

    for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
        logic                 in_seg;
        logic [NUM_ENTRY-1:0] entry_match;

        for (genvar e = 0; e < NUM_ENTRY; e++) begin : g_entry
            assign entry_match[e] = (pc_target == seg_entry[s][e]);
        end

        always_comb begin
            in_seg        = (pc_target >= seg_lo[s]) && (pc_target <= seg_hi[s]);
            restricted[s] = in_seg && !(|entry_match);
        end
    end

    always_comb begin
        hit = pc_load && (|restricted);
    end
endmodule

// File: rtl/icr_reset_ctrl.sv
module icr_reset_ctrl
    import icr_pkg::*;
#(
    parameter int ADDR_W    = 24,
    parameter int WORD_W    = 24,
    parameter int NUM_REG   = 16,
    parameter int NUM_SEG   = 2,
    parameter int NUM_ENTRY = 2,
    localparam int IDX_W    = $clog2(NUM_REG)
) (
    input  logic                                         clk,
    input  logic                                         rst_n,
    input  logic                                         fetch_vld,
    input  logic [WORD_W-1:0]                            fetch_word,
    input  logic                                         wr_vld,
    input  logic [IDX_W-1:0]                             wr_idx,
    input  logic                                         ptr_vld,
    input  logic [IDX_W-1:0]                             ptr_idx,
    input  logic                                         pc_load,
    input  logic [ADDR_W-1:0]                            pc_target,
    input  logic [NUM_SEG-1:0][ADDR_W-1:0]               seg_lo,
    input  logic [NUM_SEG-1:0][ADDR_W-1:0]               seg_hi,
    input  logic [NUM_SEG-1:0][NUM_ENTRY-1:0][ADDR_W-1:0] seg_entry,
    output logic                                         rst_req,
    output logic [CAUSE_W-1:0]                           cause
);
    logic [CAUSE_W-1:0] hit_vec;
    logic [CAUSE_W-1:0] cause_q;
    icr_state_e         state_q;
    icr_state_e         state_d;

    icr_opcode_chk #(.WORD_W(WORD_W)) u_opcode (
        .fetch_vld  (fetch_vld),
        .fetch_word (fetch_word),
        .hit        (hit_vec[CAUSE_OPCODE])
    );

    icr_wreg_track #(.NUM_REG(NUM_REG)) u_wreg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_vld  (wr_vld),
        .wr_idx  (wr_idx),
        .ptr_vld (ptr_vld),
        .ptr_idx (ptr_idx),
        .hit     (hit_vec[CAUSE_WREG])
    );

    icr_flow_guard #(
        .ADDR_W    (ADDR_W),
        .NUM_SEG   (NUM_SEG),
        .NUM_ENTRY (NUM_ENTRY)
    ) u_flow (
        .pc_load   (pc_load),
        .pc_target (pc_target),
        .seg_lo    (seg_lo),
        .seg_hi    (seg_hi),
        .seg_entry (seg_entry),
        .hit       (hit_vec[CAUSE_FLOW])
    );

    // Next-state logic: fire on any hit, hold until device reset
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WATCH:  if (|hit_vec) state_d = ST_ASSERT;
            ST_ASSERT: state_d = ST_ASSERT;
            default:   state_d = ST_WATCH;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_WATCH;
        end else begin
            state_q <= state_d;
        end
    end

    // Cause capture on the fire transition only
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cause_q <= '0;
        end else if ((state_q == ST_WATCH) && (state_d == ST_ASSERT)) begin
            cause_q <= hit_vec;
        end
    end

    // Outputs
    always_comb begin
        rst_req = (state_q == ST_ASSERT);
        cause   = cause_q;
    end
endmodule

// File: rtl/icr_checker.sv
module icr_checker #(
    parameter int WORD_W  = 24,
    parameter int IDX_W   = 4,
    parameter int CAUSE_W = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               fetch_vld,
    input logic [WORD_W-1:0]  fetch_word,
    input logic               ptr_vld,
    input logic [IDX_W-1:0]   ptr_idx,
    input logic               pc_load,
    input logic [CAUSE_W-1:0] hit_vec,
    input logic               rst_req,
    input logic [CAUSE_W-1:0] cause
);
    AST_IDLE_NO_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_req |-> (cause == '0)); // R1

    AST_OPCODE_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (!rst_req && fetch_vld && (fetch_word[WORD_W-1:WORD_W-8] == 8'h3F))
        |=> (rst_req && cause[0])); // R2

    AST_TOP_REG_EXEMPT: assert property (@(posedge clk) disable iff (!rst_n)
        (!rst_req && ptr_vld && (ptr_idx == '1) && !fetch_vld && !pc_load)
        |=> !rst_req); // R4

    AST_ALL_CAUSES: assert property (@(posedge clk) disable iff (!rst_n)
        (!rst_req && (hit_vec != '0)) |=> (cause == $past(hit_vec))); // R8

    AST_REQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> (cause != '0)); // R8

    AST_REQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> (rst_req && $stable(cause))); // R9

    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        (!rst_req && (hit_vec == '0)) |=> !rst_req); // R10
endmodule

bind icr_reset_ctrl icr_checker #(
    .WORD_W  (WORD_W),
    .IDX_W   (IDX_W),
    .CAUSE_W (icr_pkg::CAUSE_W)
) u_icr_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .fetch_vld  (fetch_vld),
    .fetch_word (fetch_word),
    .ptr_vld    (ptr_vld),
    .ptr_idx    (ptr_idx),
    .pc_load    (pc_load),
    .hit_vec    (hit_vec),
    .rst_req    (rst_req),
    .cause      (cause)
);

// File: tb/test_icr_reset_ctrl.sv
`timescale 1ns/1ps
module test_icr_reset_ctrl;
    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 fetch_vld = 1'b0;
    logic [23:0]          fetch_word = '0;
    logic                 wr_vld = 1'b0;
    logic [3:0]           wr_idx = '0;
    logic                 ptr_vld = 1'b0;
    logic [3:0]           ptr_idx = '0;
    logic                 pc_load = 1'b0;
    logic [23:0]          pc_target = '0;
    logic [1:0][23:0]     seg_lo;
    logic [1:0][23:0]     seg_hi;
    logic [1:0][1:0][23:0] seg_entry;
    logic                 rst_req;
    logic [2:0]           cause;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    icr_reset_ctrl i_icr_reset_ctrl (
        .clk(clk), .rst_n(rst_n),
        .fetch_vld(fetch_vld), .fetch_word(fetch_word),
        .wr_vld(wr_vld), .wr_idx(wr_idx),
        .ptr_vld(ptr_vld), .ptr_idx(ptr_idx),
        .pc_load(pc_load), .pc_target(pc_target),
        .seg_lo(seg_lo), .seg_hi(seg_hi), .seg_entry(seg_entry),
        .rst_req(rst_req), .cause(cause)
    );

    // Vector: {tag[3:0], fv, fw[23:0], wv, wi[3:0], pv, pi[3:0], pl, pt[23:0], exp[2:0]}
    localparam int NVEC = 15;
    localparam logic [66:0] VEC [NVEC] = '{
        {4'd2,  1'b1, 24'h3F1234, 1'b0, 4'd0, 1'b0, 4'd0,  1'b0, 24'h000000, 3'b001}, // R2 illegal
        {4'd2,  1'b1, 24'h3E1234, 1'b0, 4'd0, 1'b0, 4'd0,  1'b0, 24'h000000, 3'b000}, // R2 legal
        {4'd2,  1'b1, 24'h403F3F, 1'b0, 4'd0, 1'b0, 4'd0,  1'b0, 24'h000000, 3'b000}, // R2 low bytes
        {4'd3,  1'b0, 24'h000000, 1'b0, 4'd0, 1'b1, 4'd5,  1'b0, 24'h000000, 3'b010}, // R3
        {4'd4,  1'b0, 24'h000000, 1'b0, 4'd0, 1'b1, 4'd15, 1'b0, 24'h000000, 3'b000}, // R4
        {4'd5,  1'b0, 24'h000000, 1'b1, 4'd7, 1'b1, 4'd7,  1'b0, 24'h000000, 3'b000}, // R5 same cycle
        {4'd5,  1'b0, 24'h000000, 1'b1, 4'd6, 1'b1, 4'd7,  1'b0, 24'h000000, 3'b010}, // R5 other index
        {4'd6,  1'b0, 24'h000000, 1'b0, 4'd0, 1'b0, 4'd0,  1'b1, 24'h000300, 3'b100}, // R6 seg0
        {4'd7,  1'b0, 24'h000000, 1'b0, 4'd0, 1'b0, 4'd0,  1'b1, 24'h000280, 3'b000}, // R7 entry
        {4'd7,  1'b0, 24'h000000, 1'b0, 4'd0, 1'b0, 4'd0,  1'b1, 24'h001800, 3'b000}, // R7 entry
        {4'd7,  1'b0, 24'h000000, 1'b0, 4'd0, 1'b0, 4'd0,  1'b1, 24'h002000, 3'b000}, // R7 outside
        {4'd6,  1'b0, 24'h000000, 1'b0, 4'd0, 1'b0, 4'd0,  1'b1, 24'h001FFF, 3'b100}, // R6 upper edge
        {4'd8,  1'b1, 24'h3F0000, 1'b0, 4'd0, 1'b1, 4'd0,  1'b1, 24'h0003FF, 3'b111}, // R8
        {4'd10, 1'b0, 24'h3F0000, 1'b0, 4'd0, 1'b0, 4'd2,  1'b0, 24'h000300, 3'b000}, // R10
        {4'd7,  1'b0, 24'h000000, 1'b0, 4'd0, 1'b0, 4'd0,  1'b1, 24'h0001FF, 3'b000}  // R7 below
    };

    task automatic check(input string req, input logic [2:0] exp_c);
        logic exp_r;
        exp_r = (exp_c != 3'b000);
        checks++;
        if (rst_req !== exp_r || cause !== exp_c) begin
            failures++;
            $display("FAIL %s rst_req=%0b cause=%03b expected rst_req=%0b cause=%03b",
                     req, rst_req, cause, exp_r, exp_c);
        end
    endtask

    task automatic idle_inputs();
        fetch_vld = 1'b0; wr_vld = 1'b0; ptr_vld = 1'b0; pc_load = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        idle_inputs();
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        seg_lo[0] = 24'h000200; seg_hi[0] = 24'h0003FF;
        seg_lo[1] = 24'h001000; seg_hi[1] = 24'h001FFF;
        seg_entry[0][0] = 24'h000200; seg_entry[0][1] = 24'h000280;
        seg_entry[1][0] = 24'h001000; seg_entry[1][1] = 24'h001800;

        do_reset();
        check("R1", 3'b000);

        for (int v = 0; v < NVEC; v++) begin
            do_reset();
            {fetch_vld, fetch_word, wr_vld, wr_idx, ptr_vld, ptr_idx, pc_load, pc_target}
                = VEC[v][62:3];
            @(negedge clk);
            idle_inputs();
            check($sformatf("R%0d vec%0d", VEC[v][66:63], v), VEC[v][2:0]);
        end

        // R5: write in one cycle, pointer use in a later cycle
        do_reset();
        wr_vld = 1'b1; wr_idx = 4'd3;
        @(negedge clk);
        idle_inputs();
        ptr_vld = 1'b1; ptr_idx = 4'd3;
        @(negedge clk);
        idle_inputs();
        check("R5 written earlier", 3'b000);

        // R3: reset returns the register to uninitialised
        do_reset();
        ptr_vld = 1'b1; ptr_idx = 4'd3;
        @(negedge clk);
        idle_inputs();
        check("R3 cleared by reset", 3'b010);

        // R9: latched request ignores later faults
        do_reset();
        fetch_vld = 1'b1; fetch_word = 24'h3FABCD;
        @(negedge clk);
        idle_inputs();
        check("R9 fire", 3'b001);
        for (int k = 0; k < 3; k++) begin
            ptr_vld = 1'b1; ptr_idx = 4'd9;
            pc_load = 1'b1; pc_target = 24'h000300;
            @(negedge clk);
            idle_inputs();
            check("R9 hold", 3'b001);
        end
        do_reset();
        check("R1 after latched", 3'b000);

        // R7: empty segment (lo > hi) protects nothing
        seg_lo[1] = 24'h002000; seg_hi[1] = 24'h001000;
        do_reset();
        pc_load = 1'b1; pc_target = 24'h001400;
        @(negedge clk);
        idle_inputs();
        check("R7 empty segment", 3'b000);

        finish_run();
    end

    initial begin
        repeat (50000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end
endmodule